// File: doc/BRIEF.md
# Serial-Loaded Sixteen-Channel LED Sink Control Core

This block is the digital heart of a constant-current LED sink driver. A host shifts a pattern in one bit at a time on a slow serial clock, raises a level-sensitive latch enable to copy the shifted word into a storage register, and holds an active-low enable low to let the stored bits switch the channels. A serial output carries the oldest shifted bit, so several drivers can be chained on one data line and loaded with a single latch pulse.

All four host pins are sampled on a faster system clock through two-stage synchronisers. Serial clock rising edges are found from the sampled signal. While the sampled latch enable is high, the storage register follows the shift register on every system clock cycle.

The core also saves power on its own. If an all-zero word is latched, it enters shutdown and raises a flag that analog bias circuits can use. The first nonzero word that is latched wakes it without any command. After a wake, the channels stay off for a programmable number of system clocks, and then a ready flag rises.

Top module: `led_sink_ctrl`

## Requirements
- R1: The shift register advances only on a rising edge of `ser_clk`, never on a falling edge. The newest bit enters channel 0, so after sixteen edges the first bit sent sits at channel 15.
- R2: `ser_out` always presents bit 15 of the shift register.
- R3: While `latch_en` is high, the storage register takes the shift register contents.
- R4: While `latch_en` is low, the storage register keeps its word and further shifting does not change the channels.
- R5: With `out_en_n` low and the core ready, `chan_on[i]` is 1 exactly when stored bit i is 1.
- R6: With `out_en_n` high, every bit of `chan_on` is 0.
- R7: After reset, `shutdown` is 1, `ready` is 0, `chan_on` is all zero and `ser_out` is 0.
- R8: While `latch_en` is high, an all-zero word sets `shutdown` and a word with any bit set clears it. While `latch_en` is low, `shutdown` does not change.
- R9: After `shutdown` clears, `ready` stays 0 and all channels stay off for WAKE_CYCLES system clocks. Then `ready` rises.
- R10: While `shutdown` is 1, every bit of `chan_on` is 0 and `ready` is 0.
- R11: With two cores chained (second `ser_in` taken from first `ser_out`), 32 serial edges and one latch pulse leave the last 16 bits sent in the first core and the first 16 bits sent in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_in | input | 1 | Serial data in |
| latch_en | input | 1 | Level-sensitive latch enable, high = transparent |
| out_en_n | input | 1 | Active-low channel enable |
| ser_out | output | 1 | Cascade data out, shift register bit 15 |
| chan_on | output | CHANNELS | Channel on/off controls, 1 = sink on |
| shutdown | output | 1 | Power-save flag |
| ready | output | 1 | Wake-up delay complete |

## Verification
The bench shifts two asymmetric patterns, 0xA5C3 and 0x0F0F, so that a reversed bit order, a missed or extra shift, or a shift on the falling edge each gives a visibly different channel word. Shifting with the latch low after a pattern has been stored shows whether the storage register holds. An all-zero latch, followed by a nonzero shift that is not latched, separates entry into shutdown from wake-up. Two distinct 16-bit words sent through a chain of two cores show whether the words land in the right core in the right order.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [1:0] {
        PWR_SLEEP = 2'd0,
        PWR_WAKE  = 2'd1,
        PWR_RUN   = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lsc_shift.sv
module lsc_shift #(
    parameter int CHANNELS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                din,
    input  logic                load,
    output logic [CHANNELS-1:0] shreg_o,
    output logic [CHANNELS-1:0] store_o
);
    typedef struct packed {
        logic [CHANNELS-1:0] shreg;
        logic [CHANNELS-1:0] store;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.shreg = {st_q.shreg[CHANNELS-2:0], din};
        end
        if (load) begin
            st_d.store = st_q.shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg_o = st_q.shreg;
    assign store_o = st_q.store;
endmodule

// File: rtl/lsc_power.sv
module lsc_power
    import lsc_pkg::*;
#(
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic word_nonzero,
    output logic shutdown,
    output logic ready
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    typedef struct packed {
        pwr_state_e    state;
        logic [CW-1:0] cnt;
    } pwr_t;

    pwr_t pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        unique case (pw_q.state)
            PWR_SLEEP: begin
                if (load && word_nonzero) begin
                    pw_d.state = PWR_WAKE;
                    pw_d.cnt   = '0;
                end
            end
            PWR_WAKE: begin
                if (load && !word_nonzero) begin
                    pw_d.state = PWR_SLEEP;
                end else if (pw_q.cnt == LAST) begin
                    pw_d.state = PWR_RUN;
                end else begin
                    pw_d.cnt = pw_q.cnt + 1'b1;
                end
            end
            PWR_RUN: begin
                if (load && !word_nonzero) begin
                    pw_d.state = PWR_SLEEP;
                end
            end
            default: pw_d.state = PWR_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= '{state: PWR_SLEEP, cnt: '0};
        end else begin
            pw_q <= pw_d;
        end
    end

    assign shutdown = (pw_q.state == PWR_SLEEP);
    assign ready    = (pw_q.state == PWR_RUN);
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl #(
    parameter int CHANNELS    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_in,
    input  logic                latch_en,
    input  logic                out_en_n,
    output logic                ser_out,
    output logic [CHANNELS-1:0] chan_on,
    output logic                shutdown,
    output logic                ready
);
    localparam int NPINS = 4;

    logic [NPINS-1:0] pins_s;
    logic             sclk_s, din_s, le_s, oen_s;
    logic             sclk_d, sclk_q;
    logic             step;
    logic [CHANNELS-1:0] shreg, store;

    lsc_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({out_en_n, latch_en, ser_in, ser_clk}),
        .sync_o  (pins_s)
    );

    assign {oen_s, le_s, din_s, sclk_s} = pins_s;

    always_comb begin
        sclk_d = sclk_s;
        step   = sclk_s && !sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_d;
        end
    end

    lsc_shift #(.CHANNELS(CHANNELS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .din     (din_s),
        .load    (le_s),
        .shreg_o (shreg),
        .store_o (store)
    );

    lsc_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (le_s),
        .word_nonzero (|shreg),
        .shutdown     (shutdown),
        .ready        (ready)
    );

    assign ser_out = shreg[CHANNELS-1];
    assign chan_on = (ready && !oen_s) ? store : '0;
endmodule

// File: rtl/lsc_checks.sv
module lsc_checks #(
    parameter int CHANNELS    = 16,
    parameter int WAKE_CYCLES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                latch_en,
    input logic                out_en_n,
    input logic [CHANNELS-1:0] chan_on,
    input logic                shutdown,
    input logic                ready
);
    localparam int CW = $clog2(WAKE_CYCLES + 2);
    logic [CW-1:0] awake_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            awake_cnt <= '0;
        end else if (shutdown) begin
            awake_cnt <= '0;
        end else if (awake_cnt <= CW'(WAKE_CYCLES)) begin
            awake_cnt <= awake_cnt + 1'b1;
        end
    end

    a_r6_oe_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_n && $past(out_en_n) && $past(out_en_n, 2) && $past(out_en_n, 3)) |-> chan_on == '0);

    a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (chan_on == '0 && !ready));

    a_r8_le_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && !$past(latch_en) && !$past(latch_en, 2)) |=> $stable(shutdown));

    a_r9_ready_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> awake_cnt == CW'(WAKE_CYCLES));

    a_r9_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> chan_on == '0);
endmodule

bind led_sink_ctrl lsc_checks #(.CHANNELS(CHANNELS), .WAKE_CYCLES(WAKE_CYCLES)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (latch_en),
    .out_en_n (out_en_n),
    .chan_on  (chan_on),
    .shutdown (shutdown),
    .ready    (ready)
);

// File: tb/sim_led_sink_ctrl.sv
module sim_led_sink_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CH   = 16;
    localparam int WAKE = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_in = 1'b0, latch_en = 1'b0, out_en_n = 1'b0;
    logic ser_out0, ser_out1, shut0, shut1, rdy0, rdy1;
    logic [CH-1:0] chan0, chan1;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    led_sink_ctrl #(.CHANNELS(CH), .SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
        .latch_en(latch_en), .out_en_n(out_en_n), .ser_out(ser_out0),
        .chan_on(chan0), .shutdown(shut0), .ready(rdy0)
    );

    led_sink_ctrl #(.CHANNELS(CH), .SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) u1 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_out0),
        .latch_en(latch_en), .out_en_n(out_en_n), .ser_out(ser_out1),
        .chan_on(chan1), .shutdown(shut1), .ready(rdy1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [CH-1:0] w);
        for (int i = CH - 1; i >= 0; i--) begin
            ser_in = w[i];
            cycles(HALF);
            ser_clk = 1'b1;
            cycles(HALF);
            ser_clk = 1'b0;
            cycles(HALF);
        end
        cycles(HALF);
    endtask

    task automatic latch_pulse();
        latch_en = 1'b1;
        cycles(6);
        latch_en = 1'b0;
        cycles(6);
    endtask

    task automatic t_reset();
        check("R7 shutdown", 32'(shut0), 32'd1);
        check("R7 ready", 32'(rdy0), 32'd0);
        check("R7 chan_on", 32'(chan0), 32'd0);
        check("R7 ser_out", 32'(ser_out0), 32'd0);
    endtask

    task automatic t_load_and_wake();
        bit seen;
        send_word(16'hA5C3);
        check("R2 ser_out is bit 15", 32'(ser_out0), 32'd1);
        check("R4 no latch yet", 32'(chan0), 32'd0);
        latch_en = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            cycles(1);
            seen = !shut0;
        end
        check("R8 nonzero latch wakes", 32'(shut0), 32'd0);
        check("R9 channels gated during wake", 32'(chan0), 32'd0);
        check("R9 ready low during wake", 32'(rdy0), 32'd0);
        latch_en = 1'b0;
        cycles(WAKE + 10);
        check("R9 ready after delay", 32'(rdy0), 32'd1);
        check("R1 R3 R5 channels follow stored word", 32'(chan0), 32'h0000A5C3);
    endtask

    task automatic t_enable();
        out_en_n = 1'b1;
        cycles(6);
        check("R6 enable high forces off", 32'(chan0), 32'd0);
        out_en_n = 1'b0;
        cycles(6);
        check("R5 enable low restores", 32'(chan0), 32'h0000A5C3);
    endtask

    task automatic t_hold();
        send_word(16'h0F0F);
        check("R4 latch low holds", 32'(chan0), 32'h0000A5C3);
        check("R2 ser_out follows new bit 15", 32'(ser_out0), 32'd0);
        latch_pulse();
        check("R3 second word latched", 32'(chan0), 32'h00000F0F);
    endtask

    task automatic t_sleep();
        send_word(16'h0000);
        latch_pulse();
        check("R8 zero latch enters shutdown", 32'(shut0), 32'd1);
        check("R10 channels off in shutdown", 32'(chan0), 32'd0);
        check("R10 ready low in shutdown", 32'(rdy0), 32'd0);
        send_word(16'h8001);
        cycles(WAKE + 4);
        check("R8 latch low keeps shutdown", 32'(shut0), 32'd1);
        check("R10 still off", 32'(chan0), 32'd0);
    endtask

    task automatic t_cascade();
        send_word(16'h1234);
        send_word(16'hBEEF);
        latch_pulse();
        cycles(WAKE + 10);
        check("R11 first core holds last word", 32'(chan0), 32'h0000BEEF);
        check("R11 second core holds first word", 32'(chan1), 32'h00001234);
    endtask

    initial begin
        fork
            begin
                cycles(3);
                rst_n = 1'b1;
                cycles(2);
                t_reset();
                t_load_and_wake();
                t_enable();
                t_hold();
                t_sleep();
                t_cascade();
            end
            begin
                cycles(150000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule